// File: doc/BRIEF.md
# Posted Column Command Delay

This block sits in the command path of a DDR3-style memory device. A controller may send a READ or WRITE column command early, shortly after it opens a row with ACTIVATE. The block holds each column command for an additive latency (AL) and then passes it to the column access logic. A two-bit mode field sets AL to zero or to a value derived from the programmed CAS latency (CL). Each command takes the AL in force when it arrives, so commands already waiting keep their release time if the mode field changes later.

The block also keeps a cycle counter for each bank, restarted by ACTIVATE. A column command is legal only if the cycles since its bank's ACTIVATE, plus AL, reach the programmed minimum row-to-column delay. An early command raises a flag for one cycle. The command is still queued and released.

Top module: `posted_cas_delay`

## Requirements
- R1: After reset, `out_valid` and `early_col` are 0, and the AL mode field holds 00.
- R2: The mode field is loaded from `mr_al_sel` on a clock edge where `mr_we` is 1. Encoding: 00 gives AL=0, 01 gives AL=CL-1, 10 gives AL=CL-2, and 11 gives AL=0. CL is the 4-bit `cas_lat` input, in the range 5 to 11.
- R3: A column command captured at edge E is shown on `out_valid`/`out_write`/`out_bank`/`out_col` in the cycle after edge E+AL, for exactly one cycle.
- R4: `cmd_kind` encoding: 00 is no command, 01 is ACTIVATE, 10 is READ and 11 is WRITE. Only READ and WRITE enter the delay line. ACTIVATE produces no output.
- R5: Column commands on consecutive edges with the same AL come out on consecutive cycles, in arrival order.
- R6: AL is fixed per command at capture. A later change of the mode field does not move the release of commands already queued.
- R7: `early_col` is 1 in the cycle after a column command's edge when (edges from that bank's last ACTIVATE to the command) + AL < `trcd_min`. Otherwise it is 0.
- R8: A column command to a bank with no ACTIVATE since reset never raises `early_col`.
- R9: When a mode write and a column command share an edge, the command uses the AL in force before that write.
- R10: An ACTIVATE to one bank does not restart the interval counted for another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mr_we | input | 1 | Mode field write strobe |
| mr_al_sel | input | 2 | New AL mode field value |
| cas_lat | input | 4 | Programmed CAS latency |
| trcd_min | input | CNT_W | Minimum row-to-column delay in cycles |
| cmd_kind | input | 2 | Command type |
| cmd_bank | input | BANK_W | Command bank |
| cmd_col | input | COL_W | Command column |
| out_valid | output | 1 | Released column command present |
| out_write | output | 1 | Released command is WRITE |
| out_bank | output | BANK_W | Released command bank |
| out_col | output | COL_W | Released command column |
| early_col | output | 1 | Row-to-column timing violation flag |

## Verification
The violation flag is due in the cycle right after the edge that captures the column command. The released command is due in the cycle after edge E+AL, and it must be absent in every cycle before that and in the cycle after. The bench drives inputs and samples outputs on falling edges. It counts the rising edges since capture and checks `out_valid` at each count from 0 to AL+1, so a release that comes one cycle early or late shows up as a mismatch. The intervals since ACTIVATE are set as exact edge counts, so the tests include both cases where the interval plus AL equals the minimum delay and cases where it falls one short.

// File: rtl/posted_cas_delay.sv
module posted_cas_delay #(
  parameter int BANKS  = 8,
  parameter int BANK_W = $clog2(BANKS),
  parameter int COL_W  = 10,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mr_we,
  input  logic [1:0]        mr_al_sel,
  input  logic [3:0]        cas_lat,
  input  logic [CNT_W-1:0]  trcd_min,
  input  logic [1:0]        cmd_kind,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  output logic              out_valid,
  output logic              out_write,
  output logic [BANK_W-1:0] out_bank,
  output logic [COL_W-1:0]  out_col,
  output logic              early_col
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0]        al_sel;
  logic [3:0]        al_cur;
  logic [IDX_W-1:0]  al_idx;
  logic              is_col, is_act;

  logic              sv [DEPTH], nv [DEPTH];
  logic              sw [DEPTH], nw [DEPTH];
  logic [BANK_W-1:0] sb [DEPTH], nb [DEPTH];
  logic [COL_W-1:0]  sc [DEPTH], nc [DEPTH];
  logic [CNT_W-1:0]  cnt [BANKS];
  logic [CNT_W:0]    reach;

  assign is_act = (cmd_kind == 2'b01);
  assign is_col = cmd_kind[1];

  always_comb begin
    case (al_sel)
      2'b01:   al_cur = cas_lat - 4'd1;
      2'b10:   al_cur = cas_lat - 4'd2;
      default: al_cur = 4'd0;
    endcase
  end
  assign al_idx = IDX_W'(al_cur);
  assign reach  = {1'b0, cnt[cmd_bank]} + (CNT_W+1)'(al_cur);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     al_sel <= 2'b00;
    else if (mr_we) al_sel <= mr_al_sel;

  always_comb begin
    for (int i = 0; i < DEPTH-1; i++) begin
      nv[i] = sv[i+1]; nw[i] = sw[i+1]; nb[i] = sb[i+1]; nc[i] = sc[i+1];
    end
    nv[DEPTH-1] = 1'b0; nw[DEPTH-1] = 1'b0;
    nb[DEPTH-1] = '0;   nc[DEPTH-1] = '0;
    if (is_col && !nv[al_idx]) begin
      nv[al_idx] = 1'b1;
      nw[al_idx] = cmd_kind[0];
      nb[al_idx] = cmd_bank;
      nc[al_idx] = cmd_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        sv[i] <= 1'b0; sw[i] <= 1'b0; sb[i] <= '0; sc[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        sv[i] <= nv[i]; sw[i] <= nw[i]; sb[i] <= nb[i]; sc[i] <= nc[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++) cnt[b] <= CNT_MAX;
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        if (is_act && cmd_bank == BANK_W'(b)) cnt[b] <= CNT_W'(1);
        else if (cnt[b] != CNT_MAX)           cnt[b] <= cnt[b] + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) early_col <= 1'b0;
    else        early_col <= is_col && (reach < {1'b0, trcd_min});

  assign out_valid = sv[0];
  assign out_write = sw[0];
  assign out_bank  = sb[0];
  assign out_col   = sc[0];

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mr_we |=> al_sel == $past(mr_al_sel));  // R2
  AST_ZERO_AL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && al_cur == 4'd0 && !sv[1]) |=>
      (out_valid && out_bank == $past(cmd_bank) && out_col == $past(cmd_col)));  // R3
  AST_ACT_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && !sv[1]) |=> !out_valid);  // R4
  AST_FLAG_NEEDS_COL: assert property (@(posedge clk) disable iff (!rst_n)
    early_col |-> $past(is_col));  // R7
  AST_LATE_COL_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && cnt[cmd_bank] >= trcd_min) |=> !early_col);  // R7
  AST_ACT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |=> cnt[$past(cmd_bank)] == CNT_W'(1));  // R10
endmodule

// File: tb/posted_cas_delay_bench.sv
module posted_cas_delay_bench;
  logic       clk = 0, rst_n = 0;
  logic       mr_we = 0;
  logic [1:0] mr_al_sel = 0;
  logic [3:0] cas_lat = 4'd6;
  logic [4:0] trcd_min = 0;
  logic [1:0] cmd_kind = 0;
  logic [2:0] cmd_bank = 0;
  logic [9:0] cmd_col = 0;
  logic       out_valid, out_write, early_col;
  logic [2:0] out_bank;
  logic [9:0] out_col;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  posted_cas_delay u_posted_cas_delay (
    .clk(clk), .rst_n(rst_n), .mr_we(mr_we), .mr_al_sel(mr_al_sel),
    .cas_lat(cas_lat), .trcd_min(trcd_min), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .out_valid(out_valid),
    .out_write(out_write), .out_bank(out_bank), .out_col(out_col),
    .early_col(early_col));

  typedef struct packed {
    logic [1:0] sel; logic [3:0] cas; logic [4:0] trcd; logic [4:0] gap;
    logic wr; logic [2:0] bank; logic [9:0] col;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'b00, 4'd6,  5'd5,  5'd5, 1'b0, 3'd0, 10'h012},
    '{2'b01, 4'd6,  5'd8,  5'd3, 1'b1, 3'd1, 10'h155},
    '{2'b10, 4'd7,  5'd9,  5'd2, 1'b0, 3'd2, 10'h3FF},
    '{2'b11, 4'd9,  5'd6,  5'd2, 1'b1, 3'd3, 10'h001},
    '{2'b01, 4'd11, 5'd12, 5'd1, 1'b0, 3'd7, 10'h2A0},
    '{2'b10, 4'd5,  5'd3,  5'd1, 1'b1, 3'd4, 10'h0F0},
    '{2'b00, 4'd5,  5'd4,  5'd3, 1'b0, 3'd5, 10'h100},
    '{2'b01, 4'd5,  5'd4,  5'd1, 1'b1, 3'd6, 10'h080}
  };

  function automatic int exp_al(input logic [1:0] s, input logic [3:0] c);
    if (s == 2'b01) return int'(c) - 1;
    if (s == 2'b10) return int'(c) - 2;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    cmd_kind = 2'b00; mr_we = 0;
  endtask

  task automatic set_mode(input logic [1:0] s);
    mr_we = 1; mr_al_sel = s;
    @(negedge clk); clear_in();
  endtask

  task automatic act(input logic [2:0] b);
    cmd_kind = 2'b01; cmd_bank = b;
    @(negedge clk); clear_in();
    check(out_valid == 0, "R4 act no output", out_valid, 0);
  endtask

  task automatic col_chk(input logic wr, input logic [2:0] b, input logic [9:0] c,
                         input int al, input bit expv, input string tag);
    cmd_kind = {1'b1, wr}; cmd_bank = b; cmd_col = c;
    @(negedge clk); clear_in();
    check(early_col == expv, {tag, " R7 flag"}, early_col, expv);
    for (int n = 0; n <= al; n++) begin
      if (n < al) begin
        check(out_valid == 0, {tag, " R3 early release"}, out_valid, 0);
        @(negedge clk);
      end else begin
        check(out_valid && out_write == wr && out_bank == b && out_col == c,
              {tag, " R3 release"}, {out_valid, out_write, out_bank, out_col},
              {1'b1, wr, b, c});
      end
    end
    @(negedge clk);
    check(out_valid == 0, {tag, " R3 single cycle"}, out_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && early_col == 0, "R1 reset outputs", {out_valid, early_col}, 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0 && early_col == 0, "R1 after reset", {out_valid, early_col}, 0);

    trcd_min = 5'd20; cas_lat = 4'd9;
    col_chk(1'b0, 3'd2, 10'h0AA, 0, 1'b0, "R1 R8 no act, default AL=0");

    for (int k = 0; k < 8; k++) begin
      cas_lat = VEC[k].cas; trcd_min = VEC[k].trcd;
      set_mode(VEC[k].sel);
      act(VEC[k].bank);
      repeat (int'(VEC[k].gap) - 1) @(negedge clk);
      col_chk(VEC[k].wr, VEC[k].bank, VEC[k].col, exp_al(VEC[k].sel, VEC[k].cas),
              (int'(VEC[k].gap) + exp_al(VEC[k].sel, VEC[k].cas)) < int'(VEC[k].trcd),
              $sformatf("R2 vec%0d", k));
    end

    trcd_min = 0; cas_lat = 4'd7; set_mode(2'b10);
    cmd_kind = 2'b10; cmd_bank = 3'd1; cmd_col = 10'h101; @(negedge clk);
    cmd_kind = 2'b11; cmd_bank = 3'd2; cmd_col = 10'h102; @(negedge clk);
    cmd_kind = 2'b10; cmd_bank = 3'd3; cmd_col = 10'h103; @(negedge clk);
    clear_in();
    repeat (2) begin
      check(out_valid == 0, "R5 not yet", out_valid, 0);
      @(negedge clk);
    end
    @(negedge clk);
    check(out_valid && !out_write && out_col == 10'h101, "R5 first", out_col, 10'h101);
    @(negedge clk);
    check(out_valid && out_write && out_col == 10'h102, "R5 second", out_col, 10'h102);
    @(negedge clk);
    check(out_valid && !out_write && out_col == 10'h103, "R5 third", out_col, 10'h103);
    @(negedge clk);
    check(out_valid == 0, "R5 drained", out_valid, 0);

    cas_lat = 4'd8; set_mode(2'b01);
    cmd_kind = 2'b10; cmd_bank = 3'd1; cmd_col = 10'h011; @(negedge clk);
    clear_in(); mr_we = 1; mr_al_sel = 2'b00; @(negedge clk);
    clear_in(); cmd_kind = 2'b11; cmd_bank = 3'd4; cmd_col = 10'h022; @(negedge clk);
    clear_in();
    check(out_valid && out_col == 10'h022, "R6 new AL=0 command", out_col, 10'h022);
    repeat (4) begin
      @(negedge clk);
      check(out_valid == 0, "R6 queued not moved", out_valid, 0);
    end
    @(negedge clk);
    check(out_valid && out_col == 10'h011, "R6 queued keeps AL=7", out_col, 10'h011);

    cas_lat = 4'd6; set_mode(2'b01);
    mr_we = 1; mr_al_sel = 2'b00;
    col_chk(1'b1, 3'd5, 10'h0C3, 5, 1'b0, "R9 same-edge write");

    trcd_min = 5'd4;
    act(3'd0);
    @(negedge clk);
    act(3'd1);
    @(negedge clk);
    col_chk(1'b0, 3'd0, 10'h044, 0, 1'b0, "R10 bank0 unaffected");
    trcd_min = 5'd5;
    act(3'd2);
    repeat (3) @(negedge clk);
    col_chk(1'b1, 3'd2, 10'h055, 0, 1'b1, "R7 one short");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule